// File: doc/BRIEF.md
# Memory Access Response Watchdog

This block guards a controller against a memory that never answers. Each time the controller starts a memory access, an 8-bit countdown is loaded from a software-programmed start value and then steps down by one on every peripheral clock edge. A ready response from the memory reloads the countdown with the start value, ends the access, and parks the counter. If the countdown reaches zero first, it stops there instead of wrapping, and a sticky timeout flag is raised for the interrupt logic.

Software sees one 32-bit register word. The low byte holds the start value, which can be read and written. The next byte holds the live countdown, which is read-only. A start value of zero switches the watchdog off. The flag is cleared by a write-one pulse from the host interrupt logic. The flag does not stop a later access from restarting the counter.

Top module: `mem_resp_wdog`

## Requirements
- R1: After reset the register word reads 0x0000_0000 and the timeout flag is low.
- R2: A register write stores write-data bits 7:0 as the start value. Write-data bits 31:8 are ignored. The read word is {16'h0, live count[7:0], start value[7:0]}, so bits 31:16 always read zero.
- R3: An access-start pulse makes the live count equal the start value on the next clock edge.
- R4: While an access is outstanding and no ready arrives, the live count drops by exactly one per clock edge.
- R5: A ready pulse during an outstanding access reloads the live count with the start value and ends the access. The count then holds.
- R6: When the count steps from 1 to 0 without a ready, the flag rises on that same edge. The count stays at 0 and does not wrap.
- R7: The flag stays set until a clear pulse arrives. If a timeout and a clear fall on the same edge, the flag is set.
- R8: With a start value of zero, an access never raises the flag and the live count stays at zero.
- R9: With no access outstanding, the live count holds its value, and ready pulses have no effect on it.
- R10: A new access reloads the counter even while the flag is set, and it leaves the flag set.
- R11: An access-start pulse in the same cycle as a ready pulse counts as a start. The count loads and keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_start | input | 1 | One-cycle pulse when a memory access begins |
| mem_ready | input | 1 | Memory ready handshake |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read word: start value and live count |
| flag_clr | input | 1 | Write-one clear of the timeout flag |
| timeout_flag | output | 1 | Sticky watchdog timeout flag |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- A start or ready pulse updates the live count on the next edge.
- A register write updates the start value on the next edge.
- A timeout flag appears on the edge that takes the count from 1 to 0, which is the start value's number of edges after the load edge.

The bench drives inputs on falling edges and samples on the next falling edge. Each check therefore sees exactly one rising edge between the stimulus and the sample. The sweep runs through every start value from 1 to 10 and every ready delay from zero cycles up to past the timeout. Each expected count and flag value is computed as the start value minus the elapsed edges.

// File: rtl/mem_resp_wdog.sv
module mem_resp_wdog #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              mem_ready,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              flag_clr,
  output logic              timeout_flag
);
  localparam int PAD_W = DATA_W - 2*CNT_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cfg_q, cnt_q;
  logic             busy_q, flag_q;
  logic             expire;

  wire unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

  assign expire = busy_q && !acc_start && !mem_ready && cnt_q == ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (reg_we) cfg_q <= reg_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (acc_start) begin
      cnt_q  <= cfg_q;
      busy_q <= (cfg_q != '0);
    end else if (busy_q && mem_ready) begin
      cnt_q  <= cfg_q;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - ONE;
      busy_q <= (cnt_q != ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign reg_rdata    = {{PAD_W{1'b0}}, cnt_q, cfg_q};
  assign timeout_flag = flag_q;

  p_wr_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0]));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> reg_rdata[2*CNT_W-1:CNT_W] == $past(cfg_q));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !acc_start && !mem_ready) |=> cnt_q == $past(cnt_q) - ONE);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> reg_rdata[2*CNT_W-1:CNT_W] == '0);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !acc_start) |=> $stable(cnt_q));
endmodule

// File: tb/tb_mem_resp_wdog.sv
module tb_mem_resp_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_start = 1'b0, mem_ready = 1'b0, reg_we = 1'b0, flag_clr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        timeout_flag;
  int          n_vec = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mem_resp_wdog dut (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .mem_ready(mem_ready),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_clr(flag_clr), .timeout_flag(timeout_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int cnt, input int cfg, input bit flg);
    chk(req, reg_rdata, {16'h0, 8'(cnt), 8'(cfg)});
    chk(req, {31'h0, timeout_flag}, {31'h0, flg});
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic start_acc();
    acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  initial begin
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1 reset", 0, 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: only the low byte is written; the live byte and upper half stay put
    wr_cfg(32'hFFFF_FF05);
    @(negedge clk);
    chk_state("R2 write mask", 0, 5, 1'b0);

    // Sweep: every start value, every ready delay including none
    for (int cfg = 1; cfg <= 10; cfg++) begin
      wr_cfg(32'(cfg));
      for (int d = 0; d <= cfg; d++) begin
        clear_flag();
        start_acc();
        chk_state("R3 load", cfg, cfg, 1'b0);
        if (d < cfg) begin
          for (int j = 1; j <= d; j++) begin
            @(negedge clk);
            chk_state("R4 countdown", cfg - j, cfg, 1'b0);
          end
          mem_ready = 1'b1;
          @(negedge clk);
          mem_ready = 1'b0;
          chk_state("R5 reload on ready", cfg, cfg, 1'b0);
          repeat (3) @(negedge clk);
          chk_state("R9 hold after ready", cfg, cfg, 1'b0);
        end else begin
          for (int j = 1; j <= cfg + 2; j++) begin
            @(negedge clk);
            chk_state("R6 timeout", (cfg - j > 0) ? cfg - j : 0, cfg, (cfg - j <= 0));
          end
        end
      end
    end

    // R9: after a timeout, ready while idle does not touch the count
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    @(negedge clk);
    chk_state("R9 idle ready ignored", 0, 10, 1'b1);

    // R10: restart while flagged keeps the flag
    wr_cfg(32'd4);
    start_acc();
    chk_state("R10 restart flagged", 4, 4, 1'b1);
    @(negedge clk);
    chk_state("R10 runs flagged", 3, 4, 1'b1);

    // R11: start and ready together count as a start
    acc_start = 1'b1; mem_ready = 1'b1;
    @(negedge clk);
    acc_start = 1'b0; mem_ready = 1'b0;
    chk_state("R11 start wins", 4, 4, 1'b1);
    @(negedge clk);
    chk_state("R11 keeps running", 3, 4, 1'b1);
    repeat (3) @(negedge clk);
    clear_flag();
    chk_state("R7 clear", 0, 4, 1'b0);
    repeat (3) @(negedge clk);
    chk_state("R7 stays clear", 0, 4, 1'b0);

    // R7: timeout and clear on the same edge leaves the flag set
    wr_cfg(32'd2);
    start_acc();
    @(negedge clk);
    chk_state("R4 step", 1, 2, 1'b0);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk_state("R7 set beats clear", 0, 2, 1'b1);
    clear_flag();

    // R8: start value zero disables the watchdog
    wr_cfg(32'd0);
    start_acc();
    chk_state("R8 disabled load", 0, 0, 1'b0);
    repeat (12) @(negedge clk);
    chk_state("R8 never flags", 0, 0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule